// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

One channel that sits beside a shared free-running timer counter. The counter value, its current top value and a one-cycle wrap pulse arrive from the timer. The channel works in one of three modes. As input capture, it timestamps chosen edges of an external pin. As output compare, it changes a pin on a counter match. As edge-aligned PWM, it drives a pin whose duty is set by a 16-bit channel value.

A host reaches the channel through an 8-bit register bus with four addresses:

| Address | Register |
|---|---|
| 0 | control and status |
| 1 | configuration |
| 2 | channel value, high byte |
| 3 | channel value, low byte |

A latched event flag, gated by an interrupt enable, raises a registered interrupt request. The compare value can be used directly. It can also be held in a shadow copy that only moves at a counter wrap, so a PWM period never mixes two settings.

Control byte layout:

| Bits | Field |
|---|---|
| [1:0] | mode: 0 off, 1 capture, 2 compare, 3 PWM |
| [3:2] | action/edge field |
| [4] | toggle on wrap |
| [5] | force full duty |
| [6] | interrupt enable |
| [7] | event flag (read) / flag clear (write 1) |

Configuration bit 0 selects buffered compare. The read data register returns the addressed register one cycle after the address is presented.

Top module: `cc_channel`

## Requirements
- R1: After synchronous reset the pin output, interrupt request and read data are 0, the control and configuration registers read 0, and the channel value reads 16'hFFFF.
- R2: In capture mode the pin passes through two synchroniser flops. The action field works as an edge mask: bit 2 selects rising edges and bit 3 selects falling edges. A pin change first presented before clock edge t is latched at edge t+2, and the channel value takes the counter value present at that edge.
- R3: A capture or a compare match sets the event flag. Writing control with bit 7 set clears it. A set and a clear at the same edge leave the flag set.
- R4: The interrupt request equals (interrupt enable AND event flag) one cycle later.
- R5: In compare mode, a counter value equal to the compare value changes the pin at that edge. Action 1 toggles the pin, action 2 drives it low, action 3 drives it high, and action 0 holds it.
- R6: In compare mode with toggle-on-wrap set, the pin toggles at each wrap edge. If a match occurs at the same edge, the match action wins.
- R7: In PWM mode the pin after each edge is 1 when the counter is below the compare value and the compare value is not above the top value. Otherwise it is 0, so a compare value above the top value gives 0% duty.
- R8: In PWM mode with force-full-duty set, the pin stays at 1.
- R9: With buffering off, the compare value follows the channel value at once. With buffering on, the compare value is copied from the channel value only at wrap edges.
- R10: A high-byte write locks the channel until the next low-byte write. While locked there are no compare matches, the PWM pin holds its level, and the shadow is not loaded.
- R11: In off and capture modes the pin output is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cnt_val | input | CW | shared timer counter value |
| top_val | input | CW | timer top value (counts 0..top_val) |
| cnt_ovf | input | 1 | high in the cycle the counter wraps to 0 at the next edge |
| pin_in | input | 1 | asynchronous capture pin |
| bus_addr | input | 2 | register address |
| bus_wr | input | 1 | write strobe |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | registered read data |
| pin_out | output | 1 | registered channel output |
| irq | output | 1 | registered interrupt request |

## Verification
The hardest situations to reach from the ports are timing coincidences. One is a flag clear written in the same cycle that a capture lands. Others are a buffered compare write placed at every phase of a PWM period, and a half-written value that spans a wrap. The bench drives the counter itself, so it knows the phase of every cycle. It offsets writes by a swept number of idle cycles against the two-flop pin pipeline and the wrap point. A cycle-accurate reference model, driven from the same stimulus, predicts pin, interrupt and read data after every edge.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_CAP = 2'd1,
    MODE_CMP = 2'd2,
    MODE_PWM = 2'd3
  } cc_mode_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_CFG  = 2'd1;
  localparam logic [1:0] ADR_VHI  = 2'd2;
  localparam logic [1:0] ADR_VLO  = 2'd3;

  localparam logic [1:0] ACT_HOLD   = 2'd0;
  localparam logic [1:0] ACT_TOGGLE = 2'd1;
  localparam logic [1:0] ACT_CLEAR  = 2'd2;
  localparam logic [1:0] ACT_SET    = 2'd3;

  typedef struct packed {
    logic      ien;
    logic      maxd;
    logic      tov;
    logic [1:0] act;
    cc_mode_e  mode;
  } cc_ctrl_t;
endpackage

// File: rtl/cc_edge_detect.sv
module cc_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic rise,
  output logic fall
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/cc_ctrl_regs.sv
module cc_ctrl_regs
  import cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       evt,
  output cc_ctrl_t   ctrl,
  output logic       buf_en,
  output logic       flag,
  output logic       irq
);
  logic wr_ctrl;
  logic wr_cfg;

  assign wr_ctrl = wr && (addr == ADR_CTRL);
  assign wr_cfg  = wr && (addr == ADR_CFG);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      buf_en <= 1'b0;
      flag   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= ctrl.ien & flag;
      if (wr_ctrl) ctrl <= cc_ctrl_t'(wdata[6:0]);
      if (wr_cfg)  buf_en <= wdata[0];
      if (evt)                     flag <= 1'b1;
      else if (wr_ctrl && wdata[7]) flag <= 1'b0;
    end
  end

  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag)); // R4
endmodule

// File: rtl/cc_value_path.sv
module cc_value_path
  import cc_pkg::*;
#(
  parameter int CW         = 16,
  parameter bit HAS_SHADOW = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  input  logic          cap_evt,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic          buf_en,
  output logic [CW-1:0] chan_val,
  output logic [CW-1:0] cmp_val,
  output logic          lock
);
  localparam int HW = CW - 8;

  logic wr_hi;
  logic wr_lo;

  assign wr_hi = wr && (addr == ADR_VHI);
  assign wr_lo = wr && (addr == ADR_VLO);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_val <= '1;
      lock     <= 1'b0;
    end else if (cap_evt) begin
      chan_val <= cnt_val;
    end else if (wr_hi) begin
      chan_val[CW-1:8] <= wdata[HW-1:0];
      lock             <= 1'b1;
    end else if (wr_lo) begin
      chan_val[7:0] <= wdata;
      lock          <= 1'b0;
    end
  end

  generate
    if (HAS_SHADOW) begin : g_shadow
      logic [CW-1:0] shadow;

      always_ff @(posedge clk) begin
        if (rst)                  shadow <= '1;
        else if (cnt_ovf && !lock) shadow <= chan_val;
      end

      assign cmp_val = buf_en ? shadow : chan_val;

      AST_SHADOW_WRAP_ONLY: assert property (@(posedge clk) disable iff (rst)
        !cnt_ovf |=> $stable(shadow)); // R9
      AST_SHADOW_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(shadow)); // R10
    end else begin : g_direct
      assign cmp_val = chan_val;
    end
  endgenerate
endmodule

// File: rtl/cc_out_ctl.sv
module cc_out_ctl
  import cc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  cc_ctrl_t      ctrl,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] top_val,
  input  logic          cnt_ovf,
  input  logic [CW-1:0] cmp_val,
  input  logic          lock,
  output logic          pin_out,
  output logic          match
);
  logic cmp_mode;
  logic in_range;
  logic below;
  logic pwm_lvl;

  assign cmp_mode = (ctrl.mode == MODE_CMP) || (ctrl.mode == MODE_PWM);
  assign match    = cmp_mode && !lock && (cnt_val == cmp_val);
  assign in_range = (cmp_val <= top_val);
  assign below    = (cnt_val < cmp_val);
  assign pwm_lvl  = ctrl.maxd | (in_range & below);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
    end else begin
      unique case (ctrl.mode)
        MODE_OFF, MODE_CAP: pin_out <= 1'b0;
        MODE_CMP: begin
          if (match) begin
            unique case (ctrl.act)
              ACT_TOGGLE: pin_out <= ~pin_out;
              ACT_CLEAR:  pin_out <= 1'b0;
              ACT_SET:    pin_out <= 1'b1;
              default:    pin_out <= pin_out;
            endcase
          end else if (cnt_ovf && ctrl.tov) begin
            pin_out <= ~pin_out;
          end
        end
        MODE_PWM: if (!lock) pin_out <= pwm_lvl;
        default:  pin_out <= 1'b0;
      endcase
    end
  end

  AST_PWM_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mode == MODE_PWM && ctrl.maxd && !lock) |=> pin_out); // R8
  AST_OFF_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mode == MODE_OFF || ctrl.mode == MODE_CAP) |=> !pin_out); // R11
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_SHADOW  = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] top_val,
  input  logic          cnt_ovf,
  input  logic          pin_in,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          pin_out,
  output logic          irq
);
  cc_ctrl_t      ctrl;
  logic          buf_en;
  logic          flag;
  logic          rise;
  logic          fall;
  logic          cap_evt;
  logic          match;
  logic [CW-1:0] chan_val;
  logic [CW-1:0] cmp_val;
  logic          lock;
  logic [15:0]   val_ext;

  cc_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rise(rise), .fall(fall)
  );

  assign cap_evt = (ctrl.mode == MODE_CAP) &&
                   ((ctrl.act[0] && rise) || (ctrl.act[1] && fall));

  cc_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .evt(cap_evt | match), .ctrl(ctrl), .buf_en(buf_en), .flag(flag), .irq(irq)
  );

  cc_value_path #(.CW(CW), .HAS_SHADOW(HAS_SHADOW)) u_val (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cap_evt(cap_evt), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf), .buf_en(buf_en),
    .chan_val(chan_val), .cmp_val(cmp_val), .lock(lock)
  );

  cc_out_ctl #(.CW(CW)) u_out (
    .clk(clk), .rst(rst), .ctrl(ctrl), .cnt_val(cnt_val), .top_val(top_val),
    .cnt_ovf(cnt_ovf), .cmp_val(cmp_val), .lock(lock), .pin_out(pin_out),
    .match(match)
  );

  assign val_ext = 16'(chan_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
    end else begin
      unique case (bus_addr)
        ADR_CTRL: bus_rdata <= {flag, ctrl};
        ADR_CFG:  bus_rdata <= {7'b0, buf_en};
        ADR_VHI:  bus_rdata <= val_ext[15:8];
        default:  bus_rdata <= val_ext[7:0];
      endcase
    end
  end

  AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> flag); // R3
  AST_LOCK_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (lock && !flag && ctrl.mode != MODE_CAP) |=> !flag); // R10
endmodule

// File: tb/cc_channel_test.sv
module cc_channel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt_val = '0;
  logic [15:0] top_val = '0;
  logic        cnt_ovf = 1'b0;
  logic        pin_in = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        pin_out;
  logic        irq;

  cc_channel uut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .top_val(top_val), .cnt_ovf(cnt_ovf),
    .pin_in(pin_in), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .irq(irq)
  );

  always #4 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  bit    armed   = 1'b0;
  string cur_req = "R1";

  logic        rst_drv = 1'b1;
  logic        pin_drv = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] cnt_r = '0;
  logic [15:0] top_r = 16'd9;

  // reference model state
  logic [1:0]  m_mode, m_act;
  logic        m_tov, m_maxd, m_ien, m_flag, m_buf, m_lock, m_pin;
  logic        m_s1, m_s2, m_s3;
  logic [15:0] m_val, m_sh;
  logic        e_pin, e_irq;
  logic [7:0]  e_rd;

  task automatic chk(input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  task automatic tick(input logic w, input logic [1:0] a, input logic [7:0] d);
    logic rise, fall, cap, match, ovf;
    logic [15:0] cmpv;
    @(negedge clk);
    if (armed) begin
      chk("pin_out", int'(pin_out), int'(e_pin));
      chk("irq", int'(irq), int'(e_irq));
      chk("rdata", int'(bus_rdata), int'(e_rd));
    end
    rst = rst_drv; bus_wr = w; bus_addr = a; bus_wdata = d; pin_in = pin_drv;
    ovf = (cnt_r == top_r);
    cnt_val = cnt_r; cnt_ovf = ovf; top_val = top_r;
    if (rst_drv) begin
      m_mode = 0; m_act = 0; m_tov = 0; m_maxd = 0; m_ien = 0; m_flag = 0;
      m_buf = 0; m_lock = 0; m_pin = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_val = 16'hFFFF; m_sh = 16'hFFFF;
      e_pin = 0; e_irq = 0; e_rd = 0;
    end else begin
      rise  = m_s2 & ~m_s3;
      fall  = ~m_s2 & m_s3;
      cap   = (m_mode == 2'd1) && ((m_act[0] && rise) || (m_act[1] && fall));
      cmpv  = m_buf ? m_sh : m_val;
      match = (m_mode >= 2'd2) && !m_lock && (cnt_r == cmpv);
      case (m_mode)
        2'd2: begin
          if (match) begin
            case (m_act)
              2'd1: e_pin = ~m_pin;
              2'd2: e_pin = 1'b0;
              2'd3: e_pin = 1'b1;
              default: e_pin = m_pin;
            endcase
          end else if (ovf && m_tov) e_pin = ~m_pin;
          else e_pin = m_pin;
        end
        2'd3: e_pin = m_lock ? m_pin : (m_maxd || (cmpv <= top_r && cnt_r < cmpv));
        default: e_pin = 1'b0;
      endcase
      e_irq = m_ien & m_flag;
      case (a)
        2'd0: e_rd = {m_flag, m_ien, m_maxd, m_tov, m_act, m_mode};
        2'd1: e_rd = {7'b0, m_buf};
        2'd2: e_rd = m_val[15:8];
        default: e_rd = m_val[7:0];
      endcase
      if (ovf && !m_lock) m_sh = m_val;
      if (cap || match) m_flag = 1'b1;
      else if (w && a == 2'd0 && d[7]) m_flag = 1'b0;
      if (w && a == 2'd0) begin
        m_mode = d[1:0]; m_act = d[3:2]; m_tov = d[4]; m_maxd = d[5]; m_ien = d[6];
      end
      if (w && a == 2'd1) m_buf = d[0];
      if (cap) m_val = cnt_r;
      else if (w && a == 2'd2) begin m_val[15:8] = d; m_lock = 1'b1; end
      else if (w && a == 2'd3) begin m_val[7:0] = d; m_lock = 1'b0; end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_drv;
      m_pin = e_pin;
    end
    armed = 1'b1;
    cnt_r = ovf ? 16'd0 : cnt_r + 16'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, rd_addr, 8'h00);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    tick(1'b1, a, d);
  endtask

  task automatic set_val(input logic [15:0] v);
    wr(2'd2, v[15:8]);
    wr(2'd3, v[7:0]);
  endtask

  task automatic set_top(input logic [15:0] t);
    top_r = t;
    cnt_r = '0;
  endtask

  function automatic logic [7:0] cb(input int mode, input int act, input int tov,
                                    input int maxd, input int ien, input int clr);
    return 8'((clr << 7) | (ien << 6) | (maxd << 5) | (tov << 4) | (act << 2) | mode);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state
    cur_req = "R1";
    rst_drv = 1'b1;
    idle(3);
    rst_drv = 1'b0;
    rd_addr = 2'd0; idle(2);
    rd_addr = 2'd1; idle(2);
    rd_addr = 2'd2; idle(2);
    rd_addr = 2'd3; idle(2);

    // R2: capture edge selection, two-flop latency, counter latch
    cur_req = "R2";
    set_top(16'd99);
    for (int act = 1; act < 4; act++) begin
      wr(2'd0, cb(1, act, 0, 0, 0, 1));
      for (int k = 0; k < 6; k++) begin
        rd_addr = k[0] ? 2'd2 : 2'd3;
        pin_drv = ~pin_drv;
        idle(3 + k);
      end
    end

    // R3: flag clear coinciding with a capture; plain clear
    cur_req = "R3";
    rd_addr = 2'd0;
    wr(2'd0, cb(1, 3, 0, 0, 0, 1));
    idle(3);
    pin_drv = ~pin_drv;
    idle(2);
    wr(2'd0, cb(1, 3, 0, 0, 0, 1));
    idle(2);
    wr(2'd0, cb(1, 3, 0, 0, 0, 1));
    idle(3);

    // R4: interrupt gating
    cur_req = "R4";
    wr(2'd0, cb(1, 3, 0, 0, 1, 1));
    pin_drv = ~pin_drv;
    idle(5);
    wr(2'd0, cb(1, 3, 0, 0, 0, 0));
    idle(3);
    wr(2'd0, cb(1, 3, 0, 0, 0, 1));
    pin_drv = ~pin_drv;
    idle(5);

    // R5 and R6: compare actions, toggle on wrap, priority
    set_top(16'd9);
    for (int tov = 0; tov < 2; tov++) begin
      cur_req = (tov == 0) ? "R5" : "R6";
      for (int act = 0; act < 4; act++) begin
        for (int ci = 0; ci < 4; ci++) begin
          logic [15:0] cv;
          cv = (ci == 0) ? 16'd0 : (ci == 1) ? 16'd4 : (ci == 2) ? 16'd9 : 16'd13;
          wr(2'd0, cb(2, act, tov, 0, 1, 1));
          set_val(cv);
          idle(22);
        end
      end
    end

    // R7 and R8: PWM duty sweep including out-of-range values
    for (int maxd = 0; maxd < 2; maxd++) begin
      cur_req = (maxd == 0) ? "R7" : "R8";
      for (int cv = 0; cv < 13; cv++) begin
        wr(2'd0, cb(3, 0, 0, maxd, 0, 1));
        set_val(16'(cv));
        idle(22);
      end
    end

    // R9: unbuffered vs buffered updates at every phase of the period
    cur_req = "R9";
    wr(2'd0, cb(3, 0, 0, 0, 0, 1));
    for (int b = 0; b < 2; b++) begin
      wr(2'd1, 8'(b));
      for (int ph = 0; ph < 10; ph++) begin
        idle(ph);
        set_val(16'((ph * 3 + 2) % 11));
        idle(14);
      end
    end

    // R10: half-written value blocks matches, PWM level and shadow loads
    cur_req = "R10";
    wr(2'd1, 8'd0);
    wr(2'd0, cb(2, 1, 0, 0, 0, 1));
    set_val(16'd5);
    idle(12);
    wr(2'd2, 8'h00);
    idle(25);
    wr(2'd3, 8'd5);
    idle(15);
    wr(2'd0, cb(3, 0, 0, 0, 0, 1));
    wr(2'd1, 8'd1);
    set_val(16'd7);
    idle(12);
    wr(2'd2, 8'h00);
    idle(25);
    wr(2'd3, 8'd2);
    idle(22);

    // R11: off and capture modes drive the pin low
    cur_req = "R11";
    wr(2'd0, cb(3, 0, 0, 1, 0, 1));
    idle(4);
    wr(2'd0, cb(0, 0, 0, 0, 0, 1));
    idle(4);
    wr(2'd0, cb(3, 0, 0, 1, 0, 1));
    idle(4);
    wr(2'd0, cb(1, 0, 0, 0, 0, 1));
    idle(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule